// File: doc/BRIEF.md
# Burst-Two Double-Data-Rate Synchronous SRAM Core

This block models a small synchronous static memory that moves two words per transaction, one on each half of a clock period. A single fabric clock runs at twice the memory clock rate. An internal phase bit marks each fabric edge as either a primary-clock rise or a complementary-clock rise. Every fabric edge is therefore one half-cycle tick. A command is taken only on a primary rise. The two data words of its burst then move on one primary rise and the complementary rise that follows it.

A host drives the load strobe and the read/write select with an address on a primary rise. For a write, it presents the two data words one full cycle later. For a read, it collects the two words either two cycles later (tracking loop enabled) or one cycle later (loop disabled). A valid flag rises one tick before the first read word, so a receiver can prepare its capture. A lock-status output reports when the loop-enabled mode has seen enough stable clock cycles. Commands may be issued on every primary rise, and bursts overlap in the pipeline.

Top module: `ddrBurstSram`

## Requirements
- R1: A command is sampled only on an edge where `kPhase` was low beforehand (a primary rise). With `loadN` low, `readNotWrite` high is a read and `readNotWrite` low is a write. With `loadN` high, the edge is a no-operation. A low `loadN` on a complementary rise is ignored. After each edge, `kPhase` toggles; it is low after reset.
- R2: For a write issued at tick T, the first word is taken from `dataIn` at tick T+2 and the second word at tick T+3.
- R3: The second word of a burst goes to the partner address: the address with its least significant bit inverted. The upper bits are unchanged, so the burst wraps inside its aligned pair.
- R4: For a read issued at tick T with `lockEnable` high, the first word appears on `dataOut` with `dataOe` high after tick T+4. The second word follows after tick T+5. The first word always lands on a primary rise.
- R5: `dataValid` rises one tick before the first word of a read. It stays high through the second word and falls on the tick after that, unless another read keeps it high.
- R6: For a read issued while `lockEnable` is low, latency is one cycle. `dataValid` is high after ticks T+1..T+3, and the words appear after ticks T+2 and T+3.
- R7: `locked` goes high once `lockEnable` has been high on every edge across `LOCK_CYCLES` primary rises (default 2048), counted from reset or from the edge after it was last low. After any edge with `lockEnable` low, `locked` is low.
- R8: After reset, `dataOe`, `dataValid` and `locked` are low and `dataOut` is zero. A read of a location not written since reset returns zero.
- R9: `dataOe` is high only on read-data ticks. While it is low, `dataOut` holds the last word driven.
- R10: Commands may be issued on consecutive primary rises. A write's data phase may coincide with an earlier read's output phase. A read returns the data of every write issued before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock at twice the memory clock rate |
| rst_n | input | 1 | Active-low synchronous reset |
| loadN | input | 1 | Active-low transaction start strobe |
| readNotWrite | input | 1 | High selects read, low selects write |
| addr | input | ADDR_W | Burst start address |
| dataIn | input | DATA_W | Write data, one word per tick |
| lockEnable | input | 1 | High: tracking loop on, two-cycle read latency; low: one-cycle latency |
| dataOut | output | DATA_W | Read data word |
| dataOe | output | 1 | Output enable, high on read-data ticks |
| dataValid | output | 1 | Read-valid flag, leads data by one tick |
| locked | output | 1 | Loop lock status |
| kPhase | output | 1 | Tick phase: low means the next edge is a primary rise |

## Verification
The embedded properties watch four things on every cycle:
- the relation between the output enable and the valid flag (the flag leads the enable and both fall together);
- the landing of every first read word on a primary rise;
- the clearing of the lock status when the loop is disabled;
- that the lock status never rises without the loop enabled.

Only the scenarios can show the rest:
- the exact tick counts of each latency;
- the partner-address wrap of the second word;
- the ordering between overlapping reads and writes;
- the zero returned for unwritten locations;
- the length of the 2048-cycle lock window.

The scoreboard compares each of these against a model kept by the bench.

// File: rtl/ddrSramPkg.sv
package ddrSramPkg;

  // Half-cycle ticks from command to first write word / first read word
  localparam int WR_LAT_TICKS   = 2;
  localparam int RD_LAT_TICKS   = 4;
  localparam int RD_FAST_TICKS  = 2;

  // Strobes handed from control to datapath for the current edge
  typedef struct packed {
    logic memWr;    // write dataIn into storage at wrAddr
    logic outLoad;  // load a read word from rdAddr onto dataOut
    logic validEn;  // valid flag level after this edge
  } ctrlStrobes_t;

  function automatic int unsigned pairSlack(input int unsigned x);
    return x;
  endfunction

endpackage

// File: rtl/ddrSramLockMon.sv
module ddrSramLockMon #(
  parameter int LOCK_CYCLES = 2048
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kRise,
  input  logic lockEnable,
  output logic locked
);

  localparam int CW = $clog2(LOCK_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(LOCK_CYCLES);

  logic [CW-1:0] stableCnt;

  always_ff @(posedge clk) begin
    if (!rst_n)               stableCnt <= '0;
    else if (!lockEnable)     stableCnt <= '0;
    else if (kRise && stableCnt != LIMIT)
                              stableCnt <= stableCnt + 1'b1;
  end

  assign locked = (stableCnt == LIMIT);

  // R7
  lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lockEnable |=> !locked);

  // R7
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(lockEnable));

endmodule

// File: rtl/ddrSramCtrl.sv
module ddrSramCtrl
  import ddrSramPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loadN,
  input  logic              readNotWrite,
  input  logic [ADDR_W-1:0] addr,
  input  logic              lockEnable,
  output logic              kPhase,
  output logic              kRise,
  output ctrlStrobes_t      strb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr
);

  localparam int RD_STAGES = RD_LAT_TICKS + 1;
  localparam int WR_STAGES = WR_LAT_TICKS + 1;
  localparam int FAST_SLOT = RD_LAT_TICKS - RD_FAST_TICKS;
  localparam int RD_WORD0  = RD_LAT_TICKS - 1;
  localparam int WR_WORD0  = WR_LAT_TICKS - 1;

  logic [RD_STAGES-1:0] rdLive;
  logic [WR_STAGES-1:0] wrLive;
  logic [ADDR_W-1:0]    rdPipeAddr [RD_STAGES];
  logic [ADDR_W-1:0]    wrPipeAddr [WR_STAGES];
  logic                 cmdRead, cmdWrite;

  function automatic logic [ADDR_W-1:0] pairMate(input logic [ADDR_W-1:0] a);
    pairMate = a ^ ADDR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) kPhase <= 1'b0;
    else        kPhase <= ~kPhase;
  end

  assign kRise    = ~kPhase;
  assign cmdRead  = kRise && !loadN &&  readNotWrite;
  assign cmdWrite = kRise && !loadN && !readNotWrite;

  // Read pipeline: one stage per tick; fast mode enters part-way down
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdLive <= '0;
      for (int k = 0; k < RD_STAGES; k++) rdPipeAddr[k] <= '0;
    end else begin
      for (int k = 1; k < RD_STAGES; k++) begin
        rdLive[k]     <= rdLive[k-1];
        rdPipeAddr[k] <= rdPipeAddr[k-1];
      end
      rdLive[0]     <= cmdRead && lockEnable;
      rdPipeAddr[0] <= addr;
      if (cmdRead && !lockEnable) begin
        rdLive[FAST_SLOT]     <= 1'b1;
        rdPipeAddr[FAST_SLOT] <= addr;
      end
    end
  end

  // Write pipeline: latency independent of lock mode
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrLive <= '0;
      for (int k = 0; k < WR_STAGES; k++) wrPipeAddr[k] <= '0;
    end else begin
      for (int k = 1; k < WR_STAGES; k++) begin
        wrLive[k]     <= wrLive[k-1];
        wrPipeAddr[k] <= wrPipeAddr[k-1];
      end
      wrLive[0]     <= cmdWrite;
      wrPipeAddr[0] <= addr;
    end
  end

  always_comb begin
    strb.memWr   = wrLive[WR_WORD0] | wrLive[WR_WORD0+1];
    wrAddr       = wrLive[WR_WORD0] ? wrPipeAddr[WR_WORD0]
                                    : pairMate(wrPipeAddr[WR_WORD0+1]);
    strb.outLoad = rdLive[RD_WORD0] | rdLive[RD_WORD0+1];
    rdAddr       = rdLive[RD_WORD0] ? rdPipeAddr[RD_WORD0]
                                    : pairMate(rdPipeAddr[RD_WORD0+1]);
    strb.validEn = |rdLive[RD_STAGES-1:RD_WORD0-1];
  end

endmodule

// File: rtl/ddrSramData.sv
module ddrSramData
  import ddrSramPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobes_t      strb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              dataValid
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];
  logic [DEPTH-1:0]  written;

  always_ff @(posedge clk) begin
    if (strb.memWr) store[wrAddr] <= dataIn;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          written <= '0;
    else if (strb.memWr) written[wrAddr] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dataOut   <= '0;
      dataOe    <= 1'b0;
      dataValid <= 1'b0;
    end else begin
      if (strb.outLoad) dataOut <= written[rdAddr] ? store[rdAddr] : '0;
      dataOe    <= strb.outLoad;
      dataValid <= strb.validEn;
    end
  end

  // R9
  oe_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dataOe |-> dataValid);

  // R5
  valid_leads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dataOe) |-> $past(dataValid));

  // R5
  valid_trail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dataValid) |-> $fell(dataOe));

endmodule

// File: rtl/ddrBurstSram.sv
module ddrBurstSram #(
  parameter int  DEPTH       = 256,
  parameter int  DATA_W      = 36,
  parameter int  LOCK_CYCLES = 2048,
  localparam int ADDR_W      = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loadN,
  input  logic              readNotWrite,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              lockEnable,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              dataValid,
  output logic              locked,
  output logic              kPhase
);

  ddrSramPkg::ctrlStrobes_t strb;
  logic [ADDR_W-1:0] wrAddr, rdAddr;
  logic              kRise;

  ddrSramCtrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .loadN(loadN), .readNotWrite(readNotWrite),
    .addr(addr), .lockEnable(lockEnable), .kPhase(kPhase), .kRise(kRise),
    .strb(strb), .wrAddr(wrAddr), .rdAddr(rdAddr)
  );

  ddrSramData #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk(clk), .rst_n(rst_n), .strb(strb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe), .dataValid(dataValid)
  );

  ddrSramLockMon #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk(clk), .rst_n(rst_n), .kRise(kRise), .lockEnable(lockEnable),
    .locked(locked)
  );

  // R4
  word0_on_krise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dataOe) |-> kPhase);

endmodule

// File: tb/ddrBurstSram_tb.sv
module ddrBurstSram_tb;

  localparam int DEPTH = 256;
  localparam int AW    = 8;
  localparam int DW    = 36;
  localparam int LOCKN = 2048;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          loadN = 1'b1;
  logic          readNotWrite = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dataIn = '0;
  logic          lockEnable = 1'b1;
  logic [DW-1:0] dataOut;
  logic          dataOe, dataValid, locked, kPhase;

  ddrBurstSram #(.DEPTH(DEPTH), .DATA_W(DW), .LOCK_CYCLES(LOCKN)) u_dut (
    .clk(clk), .rst_n(rst_n), .loadN(loadN), .readNotWrite(readNotWrite),
    .addr(addr), .dataIn(dataIn), .lockEnable(lockEnable), .dataOut(dataOut),
    .dataOe(dataOe), .dataValid(dataValid), .locked(locked), .kPhase(kPhase)
  );

  always #4 clk = ~clk;

  typedef struct {
    int          due;
    logic [DW-1:0] word;
  } expItem_t;

  int            tick = 0;
  int            kCount = 0;
  int            checks = 0;
  int            failures = 0;
  bit            done = 1'b0;
  logic [DW-1:0] model [int];
  logic [DW-1:0] dinAt [int];
  bit            validDue [int];
  expItem_t      expQ [$];
  logic [DW-1:0] lastWord = '0;

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s tick=%0d actual=%0h expected=%0h", req, tick, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mate(input logic [AW-1:0] a);
    return a ^ AW'(1);
  endfunction

  function automatic logic [DW-1:0] peek(input logic [AW-1:0] a);
    return model.exists(int'(a)) ? model[int'(a)] : '0;
  endfunction

  // Independent tick and lock-window model
  always @(posedge clk) begin
    if (!rst_n) begin
      tick   <= 0;
      kCount <= 0;
    end else begin
      tick <= tick + 1;
      if (!lockEnable)                      kCount <= 0;
      else if (tick % 2 == 0 && kCount < LOCKN) kCount <= kCount + 1;
    end
  end

  // Monitor: pops scoreboard items as the design produces them
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(kPhase == tick[0], "R1 phase", kPhase, tick[0]);
      chk(dataValid == validDue.exists(tick), "R5/R6 valid", dataValid,
          validDue.exists(tick));
      if (expQ.size() > 0 && expQ[0].due == tick) begin
        chk(dataOe == 1'b1, "R4/R6 oe", dataOe, 1);
        chk(dataOut == expQ[0].word, "R2/R3/R4/R6/R10 data", dataOut, expQ[0].word);
        lastWord = expQ[0].word;
        void'(expQ.pop_front());
      end else begin
        chk(dataOe == 1'b0, "R9 oe idle", dataOe, 0);
        chk(dataOut == lastWord, "R9 hold", dataOut, lastWord);
      end
      chk(locked == (kCount >= LOCKN), "R7 lock", locked, kCount >= LOCKN);
      dataIn = dinAt.exists(tick + 1) ? dinAt[tick + 1] : DW'(36'hA5A5A5A5A) ^ DW'(tick);
    end
  end

  // Driver: issues one command on the next primary rise, records expectations
  task automatic issue(input bit rd, input logic [AW-1:0] a,
                       input logic [DW-1:0] w0, input logic [DW-1:0] w1);
    int t;
    int base;
    @(negedge clk);
    while (tick % 2 != 0) @(negedge clk);
    t = tick + 1;
    loadN = 1'b0;
    readNotWrite = rd;
    addr = a;
    if (rd) begin
      base = lockEnable ? t + 4 : t + 2;
      expQ.push_back('{due: base,     word: peek(a)});
      expQ.push_back('{due: base + 1, word: peek(mate(a))});
      for (int k = -1; k <= 1; k++) validDue[base + k] = 1'b1;
    end else begin
      model[int'(a)]       = w0;
      model[int'(mate(a))] = w1;
      dinAt[t + 2] = w0;
      dinAt[t + 3] = w1;
    end
    @(negedge clk);
    loadN = 1'b1;
  endtask

  // Strobe on a complementary rise: must be ignored (R1)
  task automatic strayCmd(input logic [AW-1:0] a);
    @(negedge clk);
    while (tick % 2 != 1) @(negedge clk);
    loadN = 1'b0;
    readNotWrite = 1'b1;
    addr = a;
    @(negedge clk);
    loadN = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog tick=%0d actual=running expected=finished", tick);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(dataOe == 1'b0, "R8 oe", dataOe, 0);
    chk(dataValid == 1'b0, "R8 valid", dataValid, 0);
    chk(dataOut == '0, "R8 data", dataOut, 0);
    chk(locked == 1'b0, "R8 locked", locked, 0);
    rst_n = 1'b1;

    issue(1, 8'h05, '0, '0);                         // R8 unwritten reads zero
    idle(6);
    issue(0, 8'h10, 36'h1_2345_6789, 36'h9_8765_4321); // R2 write
    idle(4);
    issue(1, 8'h10, '0, '0);                         // R4 normal read
    idle(6);
    issue(0, 8'h21, 36'hC_0000_00C1, 36'hD_0000_00D2); // R3 odd start wraps
    idle(2);
    issue(1, 8'h20, '0, '0);                         // R3 partner order
    idle(6);
    // R10 back-to-back mix, R5 continuous valid
    issue(1, 8'h10, '0, '0);
    issue(1, 8'h20, '0, '0);
    issue(0, 8'h30, 36'hE_EEEE_0001, 36'hF_FFFF_0002);
    issue(1, 8'h30, '0, '0);
    issue(1, 8'h11, '0, '0);
    idle(8);
    // R10 read then write same pair: read sees old data
    issue(1, 8'h40, '0, '0);
    issue(0, 8'h40, 36'h7_7777_7777, 36'h8_8888_8888);
    issue(1, 8'h41, '0, '0);
    idle(8);
    strayCmd(8'h10);                                 // R1 ignored
    idle(8);

    // R7 wait for lock
    while (tick < 2 * LOCKN + 20) @(negedge clk);

    // R6 fast mode
    lockEnable = 1'b0;
    idle(4);
    issue(1, 8'h10, '0, '0);
    idle(4);
    issue(0, 8'h50, 36'h5_0505_0505, 36'h6_0606_0606);
    issue(1, 8'h50, '0, '0);
    issue(1, 8'h31, '0, '0);
    issue(1, 8'h99, '0, '0);
    idle(8);

    // R7 relock after re-enable
    lockEnable = 1'b1;
    idle(2 * LOCKN + 20);
    issue(1, 8'h51, '0, '0);
    idle(10);

    chk(expQ.size() == 0, "R4 drained", expQ.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule